// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory burst, one address per clock. A burst is launched by a one-cycle start strobe that carries the first column, a three-bit length code and an ordering bit. From the next clock on, the block shows the current column together with a valid flag. On the final beat of a fixed-length burst it also raises a last-beat flag.

Fixed-length bursts keep their columns inside an aligned power-of-two block. In linear order the low bits count upward and wrap. In interleaved order the low bits of the start column are XORed with the beat number. The full-row mode steps linearly through all columns of the row and wraps at the end of the row. It keeps running until a stop strobe arrives or a new burst starts. A new start may replace a running burst on any cycle.

Top module: `burst_colgen`

## Requirements
- R1: After reset, and until the first start strobe, colValid and lastBeat are both 0.
- R2: When startReq is high at a clock edge, the next cycle shows colValid=1 and colOut equal to the sampled startCol (beat 0). Each later cycle of the burst presents the next beat.
- R3: lenCode selects the burst length: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8 and 3'b111=full row. The reserved codes 3'b100, 3'b101 and 3'b110 behave as length 1.
- R4: With interleave=0 and a fixed length BL, beat i shows the columns above the low log2(BL) bits unchanged. The low bits equal (start low bits + i) mod BL.
- R5: With interleave=1 and a fixed length BL, beat i shows the upper bits unchanged and the low log2(BL) bits equal to the start's low bits XOR i.
- R6: A full-row burst shows column (startCol + i) mod 256 on beat i. It wraps from 255 to 0, ignores the interleave bit, and stays valid until stopped or restarted.
- R7: lastBeat is 1 exactly on beat BL-1 of a fixed-length burst and is never 1 in full-row mode. Without a new start, colValid is 0 in the cycle after the last beat.
- R8: stopReq high at a clock edge (without startReq) makes colValid and lastBeat 0 from the next cycle on. If startReq and stopReq are high together, the start takes effect.
- R9: A start strobe during a running burst discards that burst. The next cycle shows beat 0 of the new burst with its own length and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Launches a burst with the values on startCol, lenCode and interleave |
| stopReq | input | 1 | Terminates the running burst |
| startCol | input | COL_W | First column of the burst |
| lenCode | input | 3 | Burst length code |
| interleave | input | 1 | 1 = XOR ordering, 0 = linear ordering |
| colOut | output | COL_W | Column of the current beat |
| colValid | output | 1 | colOut holds a burst beat |
| lastBeat | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The hardest state to reach is the row-end wrap of a full-row burst after it has run far past its start. The beat counter itself must roll over, not only the column. The bench starts a full-row burst near the top of the row and holds it for more than 256 beats before it stops it. It also catches running bursts at chosen beats and hits them with a restart or a stop, including a start and a stop on the same edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Strobes passed from the sequencing control to the address datapath.
  typedef struct packed {
    logic load;    // capture a new start column and ordering
    logic step;    // beat index advances this clock
    logic ilvSel;  // XOR ordering chosen for the burst being loaded
  } colStrobe_t;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_FULL = 3'b111
  } lenCode_e;

endpackage

// File: rtl/burst_colgen_ctrl.sv
module burst_colgen_ctrl
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  output colStrobe_t       stb,
  output logic [COL_W-1:0] beatCnt,
  output logic [COL_W-1:0] beatMask,
  output logic             colValid,
  output logic             lastBeat
);

  logic             active;
  logic             fullPage;
  logic [COL_W-1:0] nextMask;
  logic             nextFull;

  always_comb begin
    nextFull = 1'b0;
    nextMask = '0;
    case (lenCode)
      LEN_2:    nextMask = COL_W'(1);
      LEN_4:    nextMask = COL_W'(3);
      LEN_8:    nextMask = COL_W'(7);
      LEN_FULL: begin
        nextMask = '1;
        nextFull = 1'b1;
      end
      default:  nextMask = '0;
    endcase
  end

  assign colValid = active;
  assign lastBeat = active && !fullPage && (beatCnt == beatMask);

  always_comb begin
    stb.load   = startReq;
    stb.step   = active && !startReq && !stopReq && !lastBeat;
    stb.ilvSel = interleave && !nextFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      fullPage <= 1'b0;
      beatCnt  <= '0;
      beatMask <= '0;
    end else if (startReq) begin
      active   <= 1'b1;
      fullPage <= nextFull;
      beatCnt  <= '0;
      beatMask <= nextMask;
    end else if (stopReq) begin
      active <= 1'b0;
    end else if (active) begin
      if (lastBeat) active <= 1'b0;
      else          beatCnt <= beatCnt + 1'b1;
    end
  end

  assert_stop_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !startReq) |=> (!colValid && !lastBeat));

  assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startReq) |=> !colValid);

  assert_burst_continues_R6: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !lastBeat && !startReq && !stopReq) |=> colValid);

  assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (colValid && beatCnt == '0));

endmodule

// File: rtl/burst_colgen_dp.sv
module burst_colgen_dp
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       stb,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] beatCnt,
  input  logic [COL_W-1:0] beatMask,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] baseCol;
  logic             ilvReg;
  logic [COL_W-1:0] linLow;
  logic [COL_W-1:0] xorLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol <= '0;
      ilvReg  <= 1'b0;
    end else if (stb.load) begin
      baseCol <= startCol;
      ilvReg  <= stb.ilvSel;
    end
  end

  assign linLow = (baseCol + beatCnt) & beatMask;
  assign xorLow = (baseCol ^ beatCnt) & beatMask;
  assign colOut = (baseCol & ~beatMask) | (ilvReg ? xorLow : linLow);

  assert_load_first_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (colOut == $past(startCol)));

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> ((colOut & ~beatMask) == ($past(colOut) & ~$past(beatMask))));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !ilvReg) |=> (((colOut - $past(colOut)) & beatMask) == COL_W'(1)));

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat
);

  colStrobe_t       stb;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] beatMask;

  burst_colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .stopReq    (stopReq),
    .lenCode    (lenCode),
    .interleave (interleave),
    .stb        (stb),
    .beatCnt    (beatCnt),
    .beatMask   (beatMask),
    .colValid   (colValid),
    .lastBeat   (lastBeat)
  );

  burst_colgen_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .startCol (startCol),
    .beatCnt  (beatCnt),
    .beatMask (beatMask),
    .colOut   (colOut)
  );

  assert_last_needs_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

endmodule

// File: tb/tb_burst_colgen.sv
module tb_burst_colgen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {interleave, lenCode, startCol}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 3'b011, 8'h15},
    {1'b1, 3'b011, 8'h15},
    {1'b0, 3'b010, 8'hA6},
    {1'b1, 3'b010, 8'hA6},
    {1'b0, 3'b001, 8'h3F},
    {1'b1, 3'b001, 8'h3F},
    {1'b0, 3'b000, 8'h7C},
    {1'b1, 3'b101, 8'h80},
    {1'b0, 3'b110, 8'hFE},
    {1'b1, 3'b100, 8'h01}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       stopReq = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic [7:0] colOut;
  logic       colValid;
  logic       lastBeat;

  int nChecks = 0;
  int nFails = 0;

  burst_colgen #(.COL_W(8)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .startCol(startCol), .lenCode(lenCode), .interleave(interleave),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // 0 means full row
  function automatic int blOf(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] expCol(input logic [7:0] s, input int bl,
                                        input logic ilv, input int i);
    int off, hi;
    if (bl == 0) return 8'((int'(s) + i) % 256);
    off = int'(s) % bl;
    hi  = int'(s) - off;
    if (ilv) return 8'(hi + (off ^ (i % bl)));
    return 8'(hi + ((off + i) % bl));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic launch(input logic [7:0] s, input logic [2:0] c, input logic ilv);
    startCol = s; lenCode = c; interleave = ilv; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // checks beats 0..n-1; caller is at the negedge showing beat 0
  task automatic walkBeats(input logic [7:0] s, input int bl, input logic ilv,
                           input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(colValid === 1'b1, req, colValid, 1);
      check(colOut === expCol(s, bl, ilv, i), req, colOut, expCol(s, bl, ilv, i));
      check(lastBeat === (bl != 0 && i == bl - 1), "R7", lastBeat, (bl != 0 && i == bl - 1));
      if (i < n - 1) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(colValid === 1'b0, "R1", colValid, 0);
    check(lastBeat === 1'b0, "R1", lastBeat, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(colValid === 1'b0 && lastBeat === 1'b0, "R1", {colValid, lastBeat}, 0);

    // Table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] s;
      logic [2:0] c;
      logic       ilv;
      int         bl;
      s = VEC[v][7:0]; c = VEC[v][10:8]; ilv = VEC[v][11];
      bl = blOf(c);
      launch(s, c, ilv);
      walkBeats(s, bl, ilv, bl, ilv ? "R5" : "R4");
      @(negedge clk);
      check(colValid === 1'b0, "R7", colValid, 0);
      check(lastBeat === 1'b0, "R3", lastBeat, 0);
      @(negedge clk);
    end

    // R6: full row near the row end, interleave ignored, runs past 256 beats
    launch(8'hF0, 3'b111, 1'b1);
    walkBeats(8'hF0, 0, 1'b0, 300, "R6");
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check(colValid === 1'b0, "R8", colValid, 0);
    @(negedge clk);

    // R8: stop in the middle of an 8-beat burst
    launch(8'h20, 3'b011, 1'b0);
    walkBeats(8'h20, 8, 1'b0, 2, "R2");
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check(colValid === 1'b0 && lastBeat === 1'b0, "R8", {colValid, lastBeat}, 0);
    repeat (3) @(negedge clk);
    check(colValid === 1'b0, "R8", colValid, 0);

    // R9: restart during beat 2 of a running burst
    launch(8'h10, 3'b011, 1'b0);
    walkBeats(8'h10, 8, 1'b0, 3, "R2");
    launch(8'h42, 3'b010, 1'b1);
    walkBeats(8'h42, 4, 1'b1, 4, "R9");
    @(negedge clk);
    check(colValid === 1'b0, "R9", colValid, 0);

    // R9: restart on the last beat of a burst
    launch(8'h55, 3'b001, 1'b0);
    walkBeats(8'h55, 2, 1'b0, 2, "R9");
    launch(8'h9B, 3'b011, 1'b1);
    walkBeats(8'h9B, 8, 1'b1, 8, "R9");
    @(negedge clk);

    // R8: start and stop on the same edge, start takes effect
    startCol = 8'h33; lenCode = 3'b010; interleave = 1'b0;
    startReq = 1'b1; stopReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; stopReq = 1'b0;
    walkBeats(8'h33, 4, 1'b0, 4, "R8");
    @(negedge clk);
    check(colValid === 1'b0, "R7", colValid, 0);

    // R6: full row keeps going until a new start
    launch(8'hFD, 3'b111, 1'b0);
    walkBeats(8'hFD, 0, 1'b0, 6, "R6");
    launch(8'h07, 3'b000, 1'b0);
    walkBeats(8'h07, 1, 1'b0, 1, "R9");
    @(negedge clk);
    check(colValid === 1'b0, "R3", colValid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule